// File: doc/BRIEF.md
# I2C Clock-Synchronizing SCL Generator

This block produces the serial clock for an I2C-style controller that runs from its own internal clock. A baud counter times each half period of an internal clock. SCL is driven open-drain: the block either pulls the line low or lets it go. The sampled SCL pin level is fed back into the timing, so the effective bus clock is the wired-AND of the internal clock and the pin. When another device on the bus holds SCL low, the block waits for it. When another device pulls SCL low early, the block follows at once. As a result the bus clock always runs at the pace of the slowest device.

A transfer starts with a start pulse. It opens with a high half period before the falling edge of bit 1 and continues up to the rising edge of bit 9. What happens after the ninth rising edge depends on the control inputs. SCL can be held low from the ninth falling edge. In phase mode it can be held low from the falling edge of a tenth pulse. Otherwise it is released. A stop-detect pulse can release the line, and a force-low input pulls SCL low at any time. Start and stop generation, arbitration and the data path are handled by neighbouring blocks.

Top module: `scl_sync_gen`

## Requirements
- R1: After reset, scl_int_o=1, scl_oe_o=0, busy_o=0 and bit_cnt_o=0.
- R2: With clock synchronization off, a start accepted at clock edge 1 gives the internal clock a high half period of div_i+1 cycles, then alternating halves of div_i+1 cycles. The rising edge of bit k (k=1..9) falls on edge 1+2k(div_i+1). At that edge bit_rise_o pulses for one cycle and bit_cnt_o becomes k.
- R3: If hold_ninth_i=0 and not (phase_mode_i=1 and hold_after_i=1), the transfer ends at edge 1+19(div_i+1) and SCL is released (scl_oe_o=0, busy_o=0).
- R4: If hold_ninth_i=1, SCL is held low (scl_oe_o=1) from edge 1+19(div_i+1). This takes priority over the tenth-pulse hold. The line is released one edge after hold_ninth_i is cleared.
- R5: If hold_ninth_i=0, phase_mode_i=1 and hold_after_i=1, a tenth pulse rises at edge 1+20(div_i+1) and SCL is held low from edge 1+21(div_i+1). The line is released one edge after hold_after_i is cleared.
- R6: With sync_en_i=1, a falling edge on the SCL pin while the internal clock is high forces the internal clock low within 5 cycles. The low half then lasts exactly div_i+1 cycles from that forced edge.
- R7: With sync_en_i=1, while the internal clock is high and the pin is held low, the half period does not advance. The falling edge comes between div_i+1 and div_i+4 cycles after the pin goes high.
- R8: With sync_en_i=0, the SCL pin level has no effect on the internal clock timing.
- R9: scl_eff_o is the AND of scl_int_o and the synchronized SCL pin level.
- R10: force_low_i=1 makes scl_oe_o=1 and leaves the transfer timing unchanged.
- R11: A stop_det_i pulse with rel_on_stop_i=1 ends any transfer or hold and releases SCL by the next edge. With rel_on_stop_i=0, the pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Half period minus one, in system clocks |
| scl_i | input | 1 | SCL pin level (asynchronous) |
| start_i | input | 1 | Start-transfer pulse, accepted when idle |
| stop_det_i | input | 1 | Stop condition detected pulse |
| sync_en_i | input | 1 | Enable clock synchronization with the pin |
| hold_ninth_i | input | 1 | Hold SCL low from the ninth falling edge |
| phase_mode_i | input | 1 | Clock-phase mode, enables tenth-pulse hold |
| hold_after_i | input | 1 | Hold SCL low from the pulse after the ninth |
| rel_on_stop_i | input | 1 | Release SCL when a stop is detected |
| force_low_i | input | 1 | Pull SCL low unconditionally |
| scl_oe_o | output | 1 | Open-drain low drive for SCL |
| scl_int_o | output | 1 | Internal clock |
| scl_eff_o | output | 1 | Effective clock, internal AND pin |
| busy_o | output | 1 | Clock pulses in progress |
| bit_rise_o | output | 1 | Strobe on each internal rising edge |
| bit_fall_o | output | 1 | Strobe on each falling decision |
| bit_cnt_o | output | 4 | Number of rising edges in this transfer |

## Verification
The bench builds the block with an 8-bit divider and a two-stage synchronizer. It models the bus as a wired-AND of the block's drive and a bench-controlled external pull-down. Divider values from 0 to 7 keep every transfer short, so the table can place every one of the nine or ten rising edges at an exact cycle, across all hold choices. The two-stage synchronizer gives a fixed pin latency, which keeps the windows for forced falls and stretched highs tight.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} scl_state_e;
  localparam int unsigned CNT_W = 4;
  localparam logic [CNT_W-1:0] NINTH = 4'd9;
  localparam logic [CNT_W-1:0] TENTH = 4'd10;
endpackage

// File: rtl/scl_pin_sync.sv
module scl_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_s_o,
  output logic pin_fall_o
);
  logic [STAGES-1:0] sr_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[g] <= 1'b1;
        else if (g == 0) sr_q[g] <= pin_i;
        else sr_q[g] <= sr_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b1;
    else last_q <= sr_q[STAGES-1];
  end

  assign pin_s_o    = sr_q[STAGES-1];
  assign pin_fall_o = last_q & ~sr_q[STAGES-1];
endmodule

// File: rtl/scl_baud_cnt.sv
module scl_baud_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         en_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (en_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R7: a paused count keeps its value
  a_r7_pause_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/scl_seq.sv
module scl_seq
  import scl_gen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_det_i,
  input  logic             rel_on_stop_i,
  input  logic             sync_en_i,
  input  logic             pin_s_i,
  input  logic             pin_fall_i,
  input  logic             cnt_zero_i,
  input  logic             hold_ninth_i,
  input  logic             phase_mode_i,
  input  logic             hold_after_i,
  output logic             cnt_load_o,
  output logic             cnt_en_o,
  output logic             scl_o,
  output logic             busy_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic [CNT_W-1:0] bit_cnt_o
);
  scl_state_e       state_q;
  logic             scl_q, rise_q, fall_q, by_after_q;
  logic [CNT_W-1:0] bit_q;
  logic             accept, go, forced, tick, stop_rel, hold_free;

  always_comb begin
    accept     = (state_q == ST_IDLE) & start_i;
    go         = ~sync_en_i | pin_s_i;            // high half waits for the pin
    forced     = sync_en_i & scl_q & pin_fall_i;  // follow a faster device
    tick       = (state_q == ST_RUN) & (forced | (cnt_zero_i & (~scl_q | go)));
    cnt_en_o   = (state_q == ST_RUN) & (~scl_q | go);
    cnt_load_o = accept | tick;
    stop_rel   = stop_det_i & rel_on_stop_i;
    hold_free  = by_after_q ? ~hold_after_i : ~hold_ninth_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      scl_q      <= 1'b1;
      bit_q      <= '0;
      rise_q     <= 1'b0;
      fall_q     <= 1'b0;
      by_after_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (stop_rel) begin
        state_q <= ST_IDLE;
        scl_q   <= 1'b1;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_i) begin
            state_q <= ST_RUN;
            scl_q   <= 1'b1;
            bit_q   <= '0;
          end
          ST_RUN: if (tick) begin
            if (scl_q) begin
              fall_q <= 1'b1;
              if (bit_q == NINTH) begin
                if (hold_ninth_i) begin
                  state_q    <= ST_HOLD;
                  by_after_q <= 1'b0;
                  scl_q      <= 1'b0;
                end else if (phase_mode_i && hold_after_i) begin
                  scl_q <= 1'b0;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (bit_q == TENTH) begin
                state_q    <= ST_HOLD;
                by_after_q <= 1'b1;
                scl_q      <= 1'b0;
              end else begin
                scl_q <= 1'b0;
              end
            end else begin
              scl_q  <= 1'b1;
              rise_q <= 1'b1;
              bit_q  <= bit_q + 1'b1;
            end
          end
          ST_HOLD: if (hold_free) begin
            state_q <= ST_IDLE;
            scl_q   <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign scl_o     = scl_q;
  assign busy_o    = (state_q == ST_RUN);
  assign rise_o    = rise_q;
  assign fall_o    = fall_q;
  assign bit_cnt_o = bit_q;

  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> scl_q);
  a_r4_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> !scl_q);
  a_r2_bit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= TENTH);
  a_r2_rise_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |-> (scl_q && $past(!scl_q)));
endmodule

// File: rtl/scl_sync_gen.sv
module scl_sync_gen #(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             scl_i,
  input  logic             start_i,
  input  logic             stop_det_i,
  input  logic             sync_en_i,
  input  logic             hold_ninth_i,
  input  logic             phase_mode_i,
  input  logic             hold_after_i,
  input  logic             rel_on_stop_i,
  input  logic             force_low_i,
  output logic             scl_oe_o,
  output logic             scl_int_o,
  output logic             scl_eff_o,
  output logic             busy_o,
  output logic             bit_rise_o,
  output logic             bit_fall_o,
  output logic [3:0]       bit_cnt_o
);
  logic pin_s, pin_fall, cnt_load, cnt_en, cnt_zero, scl_int;

  scl_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i(scl_i), .pin_s_o(pin_s), .pin_fall_o(pin_fall)
  );

  scl_baud_cnt #(.W(DIV_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(cnt_load), .en_i(cnt_en), .val_i(div_i),
    .zero_o(cnt_zero)
  );

  scl_seq u_seq (
    .clk_i, .rst_ni, .start_i, .stop_det_i, .rel_on_stop_i, .sync_en_i,
    .pin_s_i(pin_s), .pin_fall_i(pin_fall), .cnt_zero_i(cnt_zero),
    .hold_ninth_i, .phase_mode_i, .hold_after_i,
    .cnt_load_o(cnt_load), .cnt_en_o(cnt_en), .scl_o(scl_int),
    .busy_o, .rise_o(bit_rise_o), .fall_o(bit_fall_o), .bit_cnt_o
  );

  assign scl_int_o = scl_int;
  assign scl_oe_o  = force_low_i | ~scl_int;
  assign scl_eff_o = scl_int & pin_s;

  // R11: released stop brings the internal clock high
  a_r11_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det_i && rel_on_stop_i) |=> scl_int_o && !busy_o);
endmodule

// File: tb/scl_sync_gen_test.sv
`timescale 1ns/1ps
module scl_sync_gen_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] div = '0;
  logic start = 0, stop_det = 0, sync_en = 0, hold9 = 0, ckph = 0, hold10 = 0;
  logic rel_stop = 0, force_low = 0, ext_low = 0;
  logic oe, sint, seff, busy, rise, fall;
  logic [3:0] bcnt;
  wire  pin = ~oe & ~ext_low;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  scl_sync_gen #(.DIV_W(8), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .scl_i(pin), .start_i(start),
    .stop_det_i(stop_det), .sync_en_i(sync_en), .hold_ninth_i(hold9),
    .phase_mode_i(ckph), .hold_after_i(hold10), .rel_on_stop_i(rel_stop),
    .force_low_i(force_low), .scl_oe_o(oe), .scl_int_o(sint), .scl_eff_o(seff),
    .busy_o(busy), .bit_rise_o(rise), .bit_fall_o(fall), .bit_cnt_o(bcnt)
  );

  // {div[15:8], rises[7:4], hold9[3], ckph[2], hold10[1], held_at_end[0]}
  localparam logic [15:0] VEC [0:5] = '{
    {8'd3, 4'd9,  1'b0, 1'b0, 1'b0, 1'b0},
    {8'd0, 4'd9,  1'b1, 1'b0, 1'b0, 1'b1},
    {8'd5, 4'd10, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'd2, 4'd9,  1'b0, 1'b0, 1'b1, 1'b0},
    {8'd4, 4'd9,  1'b1, 1'b1, 1'b1, 1'b1},
    {8'd1, 4'd9,  1'b0, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Runs one transfer with sync off; edge 1 accepts the start
  task automatic run_xfer(string tag, int d, int nr_exp, bit oe_end, bit release_it);
    int p = 1, nr = 0, bad_t = 0, end_p = -1;
    div = 8'(d);
    start = 1;
    step();
    start = 0;
    for (int i = 0; i < 5000; i++) begin
      if (rise) begin
        nr++;
        if (p != 1 + 2 * nr * (d + 1) || bcnt != 4'(nr)) bad_t++;
      end
      if (!busy) begin end_p = p; break; end
      step();
      p++;
    end
    chk({tag, " R2 rise timing errors"}, bad_t, 0);
    chk({tag, " R2 rise count"}, nr, nr_exp);
    chk({tag, " R3/R4/R5 end edge"}, end_p, 1 + (2 * nr_exp + 1) * (d + 1));
    chk({tag, " R3/R4/R5 oe at end"}, int'(oe), int'(oe_end));
    if (release_it) begin
      hold9 = 0; hold10 = 0;
      step();
      chk({tag, " R4/R5 released after clear"}, int'(oe), int'(force_low));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int c;
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1 scl_int", int'(sint), 1);
    chk("R1 oe", int'(oe), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 bit_cnt", int'(bcnt), 0);

    foreach (VEC[i]) begin
      hold9 = VEC[i][3]; ckph = VEC[i][2]; hold10 = VEC[i][1];
      run_xfer($sformatf("vec%0d", i), int'(VEC[i][15:8]), int'(VEC[i][7:4]),
               VEC[i][0], 1'b1);
      ckph = 0;
      repeat (2) step();
    end

    // R8: pin held low, sync off -> timing unchanged
    ext_low = 1;
    run_xfer("r8_pin_ignored", 3, 9, 1'b0, 1'b0);
    // R9: internal high, pin low -> effective low
    repeat (4) step();
    chk("R9 eff with pin low", int'(seff), 0);
    chk("R9 internal while pin low", int'(sint), 1);
    ext_low = 0;
    repeat (4) step();
    chk("R9 eff with pin high", int'(seff), 1);

    // R10: force low keeps oe asserted, timing unchanged
    force_low = 1;
    run_xfer("r10_force", 2, 9, 1'b1, 1'b0);
    chk("R10 oe while idle high", int'(oe && sint), 1);
    force_low = 0;
    step();

    // R11: stop without release is ignored, with release frees the line
    hold9 = 1;
    run_xfer("r11_setup", 1, 9, 1'b1, 1'b0);
    stop_det = 1; rel_stop = 0;
    step();
    stop_det = 0;
    step();
    chk("R11 no release when disabled", int'(oe), 1);
    stop_det = 1; rel_stop = 1;
    step();
    stop_det = 0;
    chk("R11 release on stop", int'(oe), 0);
    hold9 = 0;
    div = 8'd6; start = 1;
    step();
    start = 0;
    repeat (20) step();
    chk("R11 busy mid transfer", int'(busy), 1);
    stop_det = 1;
    step();
    stop_det = 0; rel_stop = 0;
    chk("R11 stop ends run", int'(busy), 0);
    chk("R11 stop frees scl", int'(oe), 0);
    repeat (3) step();

    // R6/R7: clock synchronization, div=7
    sync_en = 1; div = 8'd7; start = 1;
    step();
    start = 0;
    c = 0;
    while (!rise && c < 200) begin step(); c++; end
    c = 0;
    while (!seff && c < 20) begin step(); c++; end
    chk("R6 setup eff high", int'(seff), 1);
    ext_low = 1;
    c = 0;
    while (!fall && c < 20) begin
      step(); c++;
      if (c == 3) ext_low = 0;
    end
    ext_low = 0;
    chk_rng("R6 forced fall latency", c, 1, 5);
    chk("R6 forced fall at bit 1", int'(bcnt), 1);
    c = 0;
    while (!rise && c < 50) begin step(); c++; end
    chk("R6 low half after forced fall", c, 8);
    c = 0;
    while (!fall && c < 100) begin step(); c++; end
    ext_low = 1;
    c = 0;
    for (int k = 0; k < 40; k++) begin step(); if (fall) c++; end
    chk("R7 no fall while stretched", c, 0);
    chk("R7 internal high while stretched", int'(sint), 1);
    chk("R7 eff low while stretched", int'(seff), 0);
    ext_low = 0;
    c = 0;
    while (!fall && c < 50) begin step(); c++; end
    chk_rng("R7 fall after pin release", c, 8, 11);
    c = 0;
    while (busy && c < 2000) begin step(); c++; end
    chk("R7 transfer completes", int'(bcnt), 9);
    chk("R3 released after sync run", int'(oe), 0);

    summary();
  end
endmodule